// File: doc/BRIEF.md
# Radio Byte FIFO Pair with Threshold Interrupts

This block holds the payload bytes travelling between a host controller and the modem of a packet radio. It holds two byte-wide queues: one feeding the transmitter and one collecting received bytes. A single data address in the register space serves both directions. A host write to that address appends to the transmit queue, and a host read from it removes the oldest received byte. Burst traffic is a series of such accesses, one per byte.

Each queue raises events when its fill level crosses a programmable 6-bit byte threshold. The transmit queue has an almost-full and an almost-empty threshold, and the receive queue has an almost-full threshold. Misuse of either queue also raises events: writing when full, reading when empty, a modem push into a full receive queue, or a modem pop from an empty transmit queue. Every event latches a status bit whether or not it is enabled. An enable mask selects which latched bits drive the active-low interrupt line.

Software can empty either queue in one cycle through self-clearing control bits. An optional auto-idle mode pulses a request to return to the ready state when the modem drains the last transmit byte. The modem side is a plain pop strobe with show-ahead data for transmit, and a push strobe with data for receive.

Top module: `radio_fifo_pair`

## Requirements
- R1: A host write to address 0x7F appends the byte to the transmit queue; a host read of 0x7F returns the oldest receive byte one cycle later and removes it; the modem sees the oldest transmit byte on txData with txValid high and removes it with txPop; both queues keep first-in first-out order.
- R2: After reset the TX almost-full threshold (0x7C) reads 0x37, the TX almost-empty threshold (0x7D) reads 0x04, the RX almost-full threshold (0x7E) reads 0x37, control (0x08), enable (0x05) and status (0x03) read 0x00, irqN is high and txValid is low.
- R3: Status bit 0 sets in the cycle the transmit level rises to the 0x7C value; it does not set again while the level stays there or rises above it.
- R4: Status bit 1 sets in the cycle the transmit level falls to the 0x7D value because of a modem pop.
- R5: Status bit 2 sets in the cycle the receive level rises to the 6-bit value in bits 5:0 of 0x7E; bits 7:6 of 0x7E are not stored and read as zero.
- R6: Each queue holds 64 bytes. A host write to a full transmit queue is dropped and sets status bit 3. A host read of an empty receive queue returns 0x00 and sets status bit 4. A modem push into a full receive queue is dropped and sets bit 5. A modem pop of an empty transmit queue sets bit 6.
- R7: Reading status (0x03) returns the latched bits and clears them; a bit sets on its event whatever its enable bit holds.
- R8: irqN is low exactly while some status bit is set whose bit in the enable register (0x05) is also set.
- R9: Writing 1 to bit 0 of 0x08 empties the transmit queue and writing 1 to bit 1 empties the receive queue, both in one cycle. Neither raises a threshold event, and both bits always read back as zero.
- R10: With bit 3 of 0x08 set, idleReq is high for exactly the one cycle after the modem pop that leaves the transmit queue empty; emptying by a clear bit does not request idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 7 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Read data, valid the cycle after regRdEn |
| txPop | input | 1 | Modem takes the head transmit byte |
| txData | output | 8 | Head of the transmit queue |
| txValid | output | 1 | Transmit queue not empty |
| rxPush | input | 1 | Modem delivers a received byte |
| rxData | input | 8 | Received byte |
| irqN | output | 1 | Active-low interrupt |
| idleReq | output | 1 | One-cycle request to return to ready |

## Verification
The transmit threshold logic is driven by a monotonic fill past the almost-full level and then a drain through the almost-empty level. This separates crossing detection from level detection, and rising from falling direction, and it shows masked and unmasked events apart at irqN. The receive side is tested with a small threshold written with junk in its upper bits, followed by in-order reads down to an empty read. A full 64-byte fill plus one extra byte on each queue checks capacity, the dropped byte and ordering across pointer wrap. Clear and auto-idle runs check that a software clear neither fires a threshold event nor requests idle, while a modem drain does request idle.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  localparam logic [6:0] ADDR_DATA = 7'h7F;
  localparam logic [6:0] ADDR_TXAF = 7'h7C;
  localparam logic [6:0] ADDR_TXAE = 7'h7D;
  localparam logic [6:0] ADDR_RXAF = 7'h7E;
  localparam logic [6:0] ADDR_CTRL = 7'h08;
  localparam logic [6:0] ADDR_STAT = 7'h03;
  localparam logic [6:0] ADDR_IEN  = 7'h05;

  localparam int BIT_TXAF  = 0;
  localparam int BIT_TXAE  = 1;
  localparam int BIT_RXAF  = 2;
  localparam int BIT_TXOVF = 3;
  localparam int BIT_RXUDF = 4;
  localparam int BIT_RXOVF = 5;
  localparam int BIT_TXUDF = 6;

  localparam int CTRL_CLRTX = 0;
  localparam int CTRL_CLRRX = 1;
  localparam int CTRL_IDLE  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
  } dpStrobe_t;
endpackage

// File: rtl/rfp_byte_fifo.sv
module rfp_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    level,
  output logic [CW-1:0]    levelNext,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level == CW'(DEPTH));
  assign empty    = (level == '0);
  assign pushOk   = push && !full && !clr;
  assign popOk    = pop && !empty && !clr;
  assign headData = mem[rdPtr];

  always_comb begin
    if (clr) levelNext = '0;
    else     levelNext = level + CW'(pushOk) - CW'(popOk);
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= stepPtr(wrPtr);
      if (popOk)  rdPtr <= stepPtr(rdPtr);
      level <= levelNext;
    end
  end
endmodule

// File: rtl/rfp_datapath.sv
module rfp_datapath
  import rfp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [7:0]    hostWdata,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic [7:0]    rxData,
  output logic [7:0]    txHead,
  output logic [7:0]    rxHead,
  output logic [CW-1:0] txLevel,
  output logic [CW-1:0] txLevelNext,
  output logic [CW-1:0] rxLevel,
  output logic [CW-1:0] rxLevelNext,
  output logic          txFull,
  output logic          txEmpty,
  output logic          rxFull,
  output logic          rxEmpty
);
  rfp_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txFifo (
    .clk(clk), .rstN(rstN), .clr(strobe.txClr),
    .push(strobe.txPush), .pushData(hostWdata), .pop(txPop),
    .headData(txHead), .level(txLevel), .levelNext(txLevelNext),
    .full(txFull), .empty(txEmpty)
  );

  rfp_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxFifo (
    .clk(clk), .rstN(rstN), .clr(strobe.rxClr),
    .push(rxPush), .pushData(rxData), .pop(strobe.rxPop),
    .headData(rxHead), .level(rxLevel), .levelNext(rxLevelNext),
    .full(rxFull), .empty(rxEmpty)
  );
endmodule

// File: rtl/rfp_control.sv
module rfp_control
  import rfp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int THR_W = 6,
  parameter logic [THR_W-1:0] TXAF_RST = 6'h37,
  parameter logic [THR_W-1:0] TXAE_RST = 6'h04,
  parameter logic [THR_W-1:0] RXAF_RST = 6'h37,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [6:0]    regAddr,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [7:0]    regWdata,
  output logic [7:0]    regRdata,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic [7:0]    rxHead,
  input  logic [CW-1:0] txLevel,
  input  logic [CW-1:0] txLevelNext,
  input  logic [CW-1:0] rxLevel,
  input  logic [CW-1:0] rxLevelNext,
  input  logic          txFull,
  input  logic          txEmpty,
  input  logic          rxFull,
  input  logic          rxEmpty,
  output dpStrobe_t     strobe,
  output logic          irqN,
  output logic          idleReq
);
  logic [THR_W-1:0] txAfThr, txAeThr, rxAfThr;
  logic [7:0] status, intEn, events;
  logic autoIdle;
  logic wrData, rdData, wrCtrl, rdStat;

  assign wrData = regWrEn && (regAddr == ADDR_DATA);
  assign rdData = regRdEn && (regAddr == ADDR_DATA);
  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign rdStat = regRdEn && (regAddr == ADDR_STAT);

  always_comb begin
    strobe        = '0;
    strobe.txPush = wrData;
    strobe.rxPop  = rdData;
    strobe.txClr  = wrCtrl && regWdata[CTRL_CLRTX];
    strobe.rxClr  = wrCtrl && regWdata[CTRL_CLRRX];
  end

  always_comb begin
    events = '0;
    events[BIT_TXAF]  = !strobe.txClr && (txLevelNext > txLevel) &&
                        (txLevelNext == CW'(txAfThr));
    events[BIT_TXAE]  = !strobe.txClr && (txLevelNext < txLevel) &&
                        (txLevelNext == CW'(txAeThr));
    events[BIT_RXAF]  = !strobe.rxClr && (rxLevelNext > rxLevel) &&
                        (rxLevelNext == CW'(rxAfThr));
    events[BIT_TXOVF] = wrData && txFull;
    events[BIT_RXUDF] = rdData && rxEmpty;
    events[BIT_RXOVF] = rxPush && rxFull;
    events[BIT_TXUDF] = txPop && txEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txAfThr  <= TXAF_RST;
      txAeThr  <= TXAE_RST;
      rxAfThr  <= RXAF_RST;
      intEn    <= '0;
      autoIdle <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_TXAF: txAfThr  <= regWdata[THR_W-1:0];
        ADDR_TXAE: txAeThr  <= regWdata[THR_W-1:0];
        ADDR_RXAF: rxAfThr  <= regWdata[THR_W-1:0];
        ADDR_IEN:  intEn    <= regWdata;
        ADDR_CTRL: autoIdle <= regWdata[CTRL_IDLE];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (rdStat ? 8'h00 : status) | events;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (regRdEn) begin
      case (regAddr)
        ADDR_DATA: regRdata <= rxEmpty ? 8'h00 : rxHead;
        ADDR_STAT: regRdata <= status;
        ADDR_IEN:  regRdata <= intEn;
        ADDR_TXAF: regRdata <= 8'(txAfThr);
        ADDR_TXAE: regRdata <= 8'(txAeThr);
        ADDR_RXAF: regRdata <= 8'(rxAfThr);
        ADDR_CTRL: regRdata <= 8'(autoIdle) << CTRL_IDLE;
        default:   regRdata <= 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idleReq <= 1'b0;
    else idleReq <= autoIdle && !strobe.txClr && (txLevel != '0) &&
                    (txLevelNext == '0);
  end

  assign irqN = ~|(status & intEn);
endmodule

// File: rtl/radio_fifo_pair.sv
module radio_fifo_pair
  import rfp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int THR_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       txPop,
  output logic [7:0] txData,
  output logic       txValid,
  input  logic       rxPush,
  input  logic [7:0] rxData,
  output logic       irqN,
  output logic       idleReq
);
  localparam int CW = $clog2(DEPTH) + 1;

  dpStrobe_t strobe;
  logic [7:0] rxHead;
  logic [CW-1:0] txLevel, txLevelNext, rxLevel, rxLevelNext;
  logic txFull, txEmpty, rxFull, rxEmpty;

  rfp_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWdata(regWdata),
    .txPop(txPop), .rxPush(rxPush), .rxData(rxData),
    .txHead(txData), .rxHead(rxHead),
    .txLevel(txLevel), .txLevelNext(txLevelNext),
    .rxLevel(rxLevel), .rxLevelNext(rxLevelNext),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty)
  );

  rfp_control #(.DEPTH(DEPTH), .THR_W(THR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWdata(regWdata), .regRdata(regRdata),
    .txPop(txPop), .rxPush(rxPush), .rxHead(rxHead),
    .txLevel(txLevel), .txLevelNext(txLevelNext),
    .rxLevel(rxLevel), .rxLevelNext(rxLevelNext),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .strobe(strobe), .irqN(irqN), .idleReq(idleReq)
  );

  assign txValid = !txEmpty;
endmodule

// File: rtl/rfp_checker.sv
module rfp_checker #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic [6:0]    regAddr,
  input logic          regWrEn,
  input logic [7:0]    regWdata,
  input logic          txPop,
  input logic          txValid,
  input logic          idleReq,
  input logic [CW-1:0] txLevel
);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLevel <= CW'(DEPTH));

  // R1
  tx_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 7'h7F && txLevel < CW'(DEPTH) && !txPop)
      |=> (txLevel == $past(txLevel) + 1'b1));

  // R9
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 7'h08 && regWdata[0]) |=> !txValid);

  // R10
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleReq) |-> ($past(txPop) && !txValid));

  // R10
  idle_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |=> !idleReq);
endmodule

bind radio_fifo_pair rfp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWdata(regWdata), .txPop(txPop), .txValid(txValid),
  .idleReq(idleReq), .txLevel(txLevel)
);

// File: tb/radio_fifo_pair_bench.sv
module radio_fifo_pair_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic txPop = 1'b0;
  logic [7:0] txData;
  logic txValid;
  logic rxPush = 1'b0;
  logic [7:0] rxData = '0;
  logic irqN;
  logic idleReq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  radio_fifo_pair u_radio_fifo_pair (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWdata(regWdata), .regRdata(regRdata),
    .txPop(txPop), .txData(txData), .txValid(txValid),
    .rxPush(rxPush), .rxData(rxData), .irqN(irqN), .idleReq(idleReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdata;
  endtask

  task automatic mPop(output logic [7:0] b, output logic v);
    @(negedge clk);
    b = txData; v = txValid; txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic mPush(input logic [7:0] b);
    @(negedge clk);
    rxData = b; rxPush = 1'b1;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R2 irqN", int'(irqN), 1);
    check("R2 txValid", int'(txValid), 0);
    rd(7'h7C, d); check("R2 txaf", d, 8'h37);
    rd(7'h7D, d); check("R2 txae", d, 8'h04);
    rd(7'h7E, d); check("R2 rxaf", d, 8'h37);
    rd(7'h08, d); check("R2 ctrl", d, 8'h00);
    rd(7'h05, d); check("R2 ien", d, 8'h00);
    rd(7'h03, d); check("R2 status", d, 8'h00);
  endtask

  task automatic testTxThresholds();
    logic [7:0] d, b;
    logic v;
    wr(7'h7C, 8'd5);
    wr(7'h05, 8'h01);
    for (int i = 1; i <= 4; i++) wr(7'h7F, 8'(i));
    check("R8 irq before threshold", int'(irqN), 1);
    wr(7'h7F, 8'd5);
    check("R3 R8 irq at threshold", int'(irqN), 0);
    rd(7'h03, d); check("R3 status after fill", d, 8'h01);
    check("R7 R8 irq after status read", int'(irqN), 1);
    wr(7'h7F, 8'd6);
    rd(7'h03, d); check("R3 no retrigger above threshold", d, 8'h00);
    mPop(b, v); check("R1 first byte", b, 1);
    mPop(b, v); check("R1 second byte", b, 2);
    check("R8 masked event keeps irq high", int'(irqN), 1);
    rd(7'h03, d); check("R4 R7 almost empty latched", d, 8'h02);
    wr(7'h7D, 8'd0);
    wr(7'h08, 8'h01);
    check("R9 tx cleared", int'(txValid), 0);
    rd(7'h08, d); check("R9 clear bit reads zero", d, 8'h00);
    rd(7'h03, d); check("R9 clear raises no event", d, 8'h00);
    wr(7'h7D, 8'd4);
    wr(7'h05, 8'h00);
  endtask

  task automatic testRx();
    logic [7:0] d;
    wr(7'h7E, 8'hC3);
    rd(7'h7E, d); check("R5 upper bits dropped", d, 8'h03);
    wr(7'h05, 8'h04);
    mPush(8'hA0); mPush(8'hA1);
    check("R8 rx irq idle", int'(irqN), 1);
    mPush(8'hA2);
    check("R5 R8 rx irq", int'(irqN), 0);
    rd(7'h03, d); check("R5 rx almost full", d, 8'h04);
    rd(7'h7F, d); check("R1 rx byte0", d, 8'hA0);
    rd(7'h7F, d); check("R1 rx byte1", d, 8'hA1);
    rd(7'h7F, d); check("R1 rx byte2", d, 8'hA2);
    rd(7'h7F, d); check("R6 empty read data", d, 8'h00);
    rd(7'h03, d); check("R6 rx underflow", d, 8'h10);
    mPush(8'h11); mPush(8'h22);
    wr(7'h08, 8'h02);
    rd(7'h7F, d); check("R9 rx cleared data", d, 8'h00);
    rd(7'h03, d); check("R9 rx cleared underflow", d & 8'h10, 8'h10);
    wr(7'h05, 8'h00);
    wr(7'h7E, 8'h37);
  endtask

  task automatic testCapacity();
    logic [7:0] d, b;
    logic v;
    int bad;
    rd(7'h03, d);
    for (int i = 0; i < 64; i++) wr(7'h7F, 8'(i));
    wr(7'h7F, 8'hEE);
    rd(7'h03, d); check("R6 tx overflow", d & 8'h08, 8'h08);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      mPop(b, v);
      if (!v || b != 8'(i)) bad++;
    end
    check("R6 R1 64 bytes in order", bad, 0);
    check("R6 extra byte dropped", int'(txValid), 0);
    mPop(b, v);
    rd(7'h03, d); check("R6 tx underflow", d & 8'h40, 8'h40);
    for (int i = 0; i < 65; i++) mPush(8'(i));
    rd(7'h03, d); check("R6 rx overflow", d & 8'h20, 8'h20);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      rd(7'h7F, d);
      if (d != 8'(i)) bad++;
    end
    check("R6 rx 64 in order", bad, 0);
    rd(7'h03, d);
  endtask

  task automatic testAutoIdle();
    logic [7:0] d, b;
    logic v;
    wr(7'h08, 8'h08);
    rd(7'h08, d); check("R9 R10 ctrl keeps idle bit", d, 8'h08);
    wr(7'h7F, 8'h55); wr(7'h7F, 8'h66);
    mPop(b, v);
    check("R10 no idle while bytes remain", int'(idleReq), 0);
    mPop(b, v);
    check("R10 idle pulse", int'(idleReq), 1);
    @(negedge clk);
    check("R10 idle one cycle", int'(idleReq), 0);
    wr(7'h7F, 8'h77);
    wr(7'h08, 8'h09);
    check("R10 clear gives no idle", int'(idleReq), 0);
    wr(7'h08, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTxThresholds();
    testRx();
    testCapacity();
    testAutoIdle();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule